// File: doc/BRIEF.md
# Polyline Delta Character Encoder

This block turns a stream of signed 32-bit coordinate values into a compact stream of printable ASCII characters. Each value arrives tagged with a stream index, for example latitude or longitude. The block subtracts the previous value of that same stream. It folds the sign of the difference into the least significant bit. It then emits the folded number as a run of 5-bit groups, least significant group first. Every group except the last carries a continuation flag. Every group is offset by 63, so each character lands in the printable range.

Values enter on a valid/ready handshake. Characters leave on a second valid/ready handshake that may stall at any time. A one-cycle start-of-line strobe zeroes every stream's history so that a new polyline starts from absolute values. One value is encoded at a time. The block takes a new value once the last character of the current one has been accepted.

Top module: `polyline_delta_encoder`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1, and every stream's history is zero, so the first value of each stream is encoded against zero.
- R2: The encoded quantity is `in_value` minus the last accepted value of the stream selected by `in_sel`. Each stream keeps its own history, and values of one stream do not change another stream's history.
- R3: The difference is taken modulo 2^32 and shifted left by one bit. When the difference is negative, every bit of the shifted word is inverted.
- R4: The folded word is emitted in 5-bit groups, bits [4:0] first, then [9:5], and so on. Emission stops after the highest group that holds a nonzero bit. A difference of -2^31 therefore yields 7 characters.
- R5: Every character except the last of a value has the group value ORed with 0x20. The last character has bit 0x20 of its group clear.
- R6: Each character equals its 6-bit group plus 63. Every character lies in the range 63 to 126 inclusive.
- R7: A zero difference produces exactly one character, 63.
- R8: A high `start_line` zeroes all histories. If a value is accepted in the same cycle, that value is encoded against zero and becomes its stream's new history.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_char` holds its value into the next cycle.
- R10: A value accepted on a clock edge presents its first character from the next cycle on. `in_ready` is 0 while characters are pending and returns to 1 in the cycle after the last character is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_line | input | 1 | Clears all stream histories |
| in_valid | input | 1 | Input value present |
| in_ready | output | 1 | Encoder can take a value |
| in_sel | input | 1 | Stream index of the value (SEL_W bits) |
| in_value | input | 32 | Signed coordinate value |
| out_valid | output | 1 | Character present |
| out_ready | input | 1 | Consumer takes the character |
| out_char | output | 8 | Printable encoded character |

## Verification
The bench builds the block with its defaults: a 32-bit value width and two streams. With two streams, a latitude/longitude pair can be interleaved and each stream's delta history checked in isolation. The full 32-bit width allows the most negative difference, which yields the longest, seven-character output and the highest character codes. Known multi-point sequences are run both with a free-flowing consumer and with one that stalls every third cycle.

// File: rtl/polyenc_pkg.sv
`timescale 1ns/1ps
package polyenc_pkg;
  localparam int CHUNK_W   = 5;
  localparam int CHAR_W    = 8;
  localparam logic [CHAR_W-1:0] CONT_FLAG = 8'h20;
  localparam logic [CHAR_W-1:0] CHAR_BIAS = 8'd63;

  function automatic int chunk_count(input int value_w);
    return (value_w + CHUNK_W - 1) / CHUNK_W;
  endfunction
endpackage

// File: rtl/pe_history.sv
`timescale 1ns/1ps
module pe_history #(
  parameter int VALUE_W = 32,
  parameter int STREAMS = 2,
  parameter int SEL_W   = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               upd,
  input  logic [SEL_W-1:0]   sel,
  input  logic [VALUE_W-1:0] value,
  output logic [VALUE_W-1:0] delta
);
  logic [VALUE_W-1:0] prev_q [STREAMS];
  logic [VALUE_W-1:0] prev_sel;

  always_comb begin
    prev_sel = '0;
    for (int s = 0; s < STREAMS; s++) begin
      if (sel == SEL_W'(s)) prev_sel = prev_q[s];
    end
  end

  // a clear applies before the difference of a value taken in the same cycle
  assign delta = value - (clear ? '0 : prev_sel);

  for (genvar s = 0; s < STREAMS; s++) begin : g_hist
    logic               hit;
    logic               en;
    logic [VALUE_W-1:0] prev_d;

    assign hit = upd && (sel == SEL_W'(s));
    assign en  = hit || clear;

    always_comb begin
      prev_d = prev_q[s];
      if (clear) prev_d = '0;
      if (hit)   prev_d = value;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  prev_q[s] <= '0;
      else if (en) prev_q[s] <= prev_d;
    end
  end
endmodule

// File: rtl/pe_fold.sv
`timescale 1ns/1ps
module pe_fold #(
  parameter int VALUE_W = 32
) (
  input  logic [VALUE_W-1:0] delta,
  output logic [VALUE_W-1:0] folded
);
  logic [VALUE_W-1:0] shifted;

  assign shifted = {delta[VALUE_W-2:0], 1'b0};
  assign folded  = delta[VALUE_W-1] ? ~shifted : shifted;
endmodule

// File: rtl/pe_chunker.sv
`timescale 1ns/1ps
module pe_chunker
  import polyenc_pkg::*;
#(
  parameter int VALUE_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [VALUE_W-1:0] load_word,
  input  logic               take,
  output logic               busy,
  output logic [CHAR_W-1:0]  char_o
);
  logic [VALUE_W-1:0] word_q, word_d;
  logic               busy_q, busy_d;
  logic [VALUE_W-1:0] rest;
  logic               more;
  logic [CHAR_W-1:0]  group;
  logic               en;

  assign rest  = word_q >> CHUNK_W;
  assign more  = (rest != '0);
  assign group = CHAR_W'(word_q[CHUNK_W-1:0]) | (more ? CONT_FLAG : '0);
  assign char_o = group + CHAR_BIAS;
  assign busy  = busy_q;

  assign en = load || (busy_q && take);

  always_comb begin
    word_d = word_q;
    busy_d = busy_q;
    if (load) begin
      word_d = load_word;
      busy_d = 1'b1;
    end else if (busy_q && take) begin
      word_d = rest;
      busy_d = more;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      busy_q <= 1'b0;
    end else if (en) begin
      word_q <= word_d;
      busy_q <= busy_d;
    end
  end
endmodule

// File: rtl/polyline_delta_encoder.sv
`timescale 1ns/1ps
module polyline_delta_encoder
  import polyenc_pkg::*;
#(
  parameter int VALUE_W = 32,
  parameter int STREAMS = 2,
  localparam int SEL_W  = (STREAMS > 1) ? $clog2(STREAMS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_line,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [SEL_W-1:0]   in_sel,
  input  logic [VALUE_W-1:0] in_value,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [CHAR_W-1:0]  out_char
);
  logic               accept;
  logic               busy;
  logic [VALUE_W-1:0] delta;
  logic [VALUE_W-1:0] folded;

  assign in_ready  = !busy;
  assign accept    = in_valid && in_ready;
  assign out_valid = busy;

  pe_history #(.VALUE_W(VALUE_W), .STREAMS(STREAMS), .SEL_W(SEL_W)) u_hist (
    .clk(clk), .rst_n(rst_n), .clear(start_line), .upd(accept),
    .sel(in_sel), .value(in_value), .delta(delta)
  );

  pe_fold #(.VALUE_W(VALUE_W)) u_fold (
    .delta(delta), .folded(folded)
  );

  pe_chunker #(.VALUE_W(VALUE_W)) u_chunk (
    .clk(clk), .rst_n(rst_n), .load(accept), .load_word(folded),
    .take(out_ready), .busy(busy), .char_o(out_char)
  );
endmodule

// File: rtl/pe_checker.sv
`timescale 1ns/1ps
module pe_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_char
);
  logic [7:0] grp;
  assign grp = out_char - 8'd63;

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_char)));

  p_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_char >= 8'd63 && out_char <= 8'd126));

  p_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  p_cont_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && grp[5]) |=> out_valid);

  p_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !grp[5]) |=> !out_valid);
endmodule

bind polyline_delta_encoder pe_checker u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_char(out_char)
);

// File: tb/sim_polyline_delta_encoder.sv
`timescale 1ns/1ps
module sim_polyline_delta_encoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_line = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [0:0]  in_sel = '0;
  logic [31:0] in_value = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [7:0]  out_char;

  int checks = 0;
  int errors = 0;
  logic [31:0] model_prev [2];

  always #2 clk = ~clk;

  polyline_delta_encoder u0 (
    .clk(clk), .rst_n(rst_n), .start_line(start_line), .in_valid(in_valid),
    .in_ready(in_ready), .in_sel(in_sel), .in_value(in_value),
    .out_valid(out_valid), .out_ready(out_ready), .out_char(out_char)
  );

  // known sequences: stream 0 and stream 1 interleaved, expected text first char highest
  localparam int NV = 6;
  localparam logic [0:0]  T_SEL [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};
  localparam logic [31:0] T_VAL [NV] = '{32'd3850000, -32'sd12020000, 32'd4070000,
                                         -32'sd12095000, 32'd4325200, -32'sd12645300};
  localparam logic [55:0] T_EXP [NV] = '{56'("_p~iF"), 56'("~ps|U"), 56'("_ulL"),
                                         56'("nnqC"), 56'("_mqN"), 56'({"vxq", 8'h60, 8'h40})};
  localparam int T_LEN [NV] = '{5, 5, 4, 4, 4, 5};

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected text from the requirements: fold (R3), 5-bit groups (R4), flag (R5), bias (R6)
  function automatic void ref_encode(input logic [31:0] d, output logic [55:0] txt, output int len);
    logic [31:0] f;
    f = {d[30:0], 1'b0};
    if (d[31]) f = ~f;
    txt = '0; len = 0;
    do begin
      logic [7:0] g;
      g = {3'b000, f[4:0]};
      f = f >> 5;
      if (f != 0) g = g | 8'h20;
      txt = (txt << 8) | 56'(g + 8'd63);
      len++;
    end while (f != 0);
  endfunction

  task automatic send(input logic s, input logic [31:0] v, input logic st);
    @(negedge clk);
    in_valid = 1'b1; in_sel = s; in_value = v; start_line = st;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1 in_valid = 1'b0; start_line = 1'b0;
  endtask

  task automatic expect_text(input logic [55:0] txt, input int len, input int mode, input string req);
    int got = 0;
    int guard = 0;
    while (got < len && guard < 200) begin
      @(negedge clk);
      out_ready = (mode == 0) || (guard % 3 != 0);
      guard++;
      if (out_valid && out_ready) begin
        check(out_char == txt[8*(len-1-got) +: 8], req, 64'(out_char), 64'(txt[8*(len-1-got) +: 8]));
        got++;
      end
    end
    check(got == len, req, 64'(got), 64'(len));
    @(negedge clk);
    out_ready = 1'b0;
    check(!out_valid && in_ready, "R10 idle after last char", {out_valid, in_ready}, 64'b01);
  endtask

  task automatic run_value(input logic s, input logic [31:0] v, input logic st, input int mode, input string req);
    logic [55:0] txt;
    int len;
    if (st) begin model_prev[0] = '0; model_prev[1] = '0; end
    ref_encode(v - model_prev[s], txt, len);
    model_prev[s] = v;
    send(s, v, st);
    expect_text(txt, len, mode, req);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    model_prev[0] = '0; model_prev[1] = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(out_valid == 1'b0, "R1 out_valid after reset", 64'(out_valid), 0);
    check(in_ready == 1'b1, "R1 in_ready after reset", 64'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R4 R5 R6: interleaved streams from zero history, free then stalling consumer (R9)
    for (int pass = 0; pass < 2; pass++) begin
      for (int i = 0; i < NV; i++) begin
        if (i == 0) begin model_prev[0] = '0; model_prev[1] = '0; end
        send(T_SEL[i], T_VAL[i], (i == 0) ? 1'b1 : 1'b0);
        model_prev[T_SEL[i]] = T_VAL[i];
        expect_text(T_EXP[i], T_LEN[i], pass, pass ? "R9 stalled table" : "R2 R4 table");
      end
    end

    // R7: repeat of the last value gives a zero difference -> single '?'
    send(1'b1, -32'sd12645300, 1'b0);
    expect_text(56'd63, 1, 0, "R7 zero delta");
    // R3: delta -1 -> 64, delta +1 -> 65
    send(1'b0, 32'd4325199, 1'b0);
    expect_text(56'd64, 1, 0, "R3 delta minus one");
    send(1'b0, 32'd4325200, 1'b0);
    expect_text(56'd65, 1, 0, "R3 delta plus one");
    model_prev[0] = 32'd4325200; model_prev[1] = -32'sd12645300;
    // R4 R5: boundary of one group (delta 15 -> 93) and two groups (delta 16 -> 95,64)
    run_value(1'b0, 32'd4325215, 1'b0, 0, "R4 single group limit");
    send(1'b0, 32'd4325231, 1'b0);
    model_prev[0] = 32'd4325231;
    expect_text({8'd95, 8'd64}, 2, 0, "R5 two groups");

    // R8: start_line alone clears both streams; 100 then encodes as 'g','E'
    @(negedge clk); start_line = 1'b1;
    @(negedge clk); start_line = 1'b0;
    model_prev[0] = '0; model_prev[1] = '0;
    send(1'b0, 32'd100, 1'b0);
    model_prev[0] = 32'd100;
    expect_text({8'd103, 8'd69}, 2, 0, "R8 clear then value");
    run_value(1'b1, -32'sd5, 1'b0, 0, "R8 other stream cleared");
    // R8: clear together with a value: 7 against zero -> 77
    send(1'b0, 32'd7, 1'b1);
    model_prev[0] = 32'd7; model_prev[1] = '0;
    expect_text(56'd77, 1, 1, "R8 clear with accept");

    // R11-like corner under R4: most negative difference -> seven chars, max code 126
    @(negedge clk); start_line = 1'b1;
    @(negedge clk); start_line = 1'b0;
    model_prev[0] = '0; model_prev[1] = '0;
    send(1'b1, 32'h8000_0000, 1'b0);
    model_prev[1] = 32'h8000_0000;
    expect_text({8'd126, 8'd126, 8'd126, 8'd126, 8'd126, 8'd126, 8'd66}, 7, 1, "R4 R6 seven groups");
    // R3: wrap of the 32-bit difference (0x7fffffff - 0x80000000 = -1) -> 64
    send(1'b1, 32'h7fff_ffff, 1'b0);
    expect_text(56'd64, 1, 0, "R3 modulo difference");

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule